// File: doc/BRIEF.md
# Bus Latency Timeout Monitor

This block measures how long a bus master has been waiting for ownership of the bus after raising its request. It divides a crystal-derived enable pulse into fixed time units of 0.1 µs and compares the number of units waited against a programmable 16-bit limit. When the limit is reached while the request is still unanswered, a sticky memory-error flag is raised. The flag can also produce an interrupt, gated by a mask bit and a global interrupt enable.

The limit is a host register. It can be written and read back only while the controller is stopped. Hard and soft reset both load it with 512 units (51.2 µs). A limit of zero turns the timeout off altogether. Every new request restarts the measurement. Time spent holding the grant does not count toward the wait.

Top module: `buswait_mon`

## Requirements
- R1: After hard reset (`rst` high at a clock edge), `merr_o` and `irq_o` are 0 and, with `stop_i` high, `reg_rdata_o` reads 0x0200.
- R2: A soft reset (`soft_rst_i` high at an edge) also reloads the limit with 0x0200 and clears `merr_o`.
- R3: With limit N ≠ 0, `merr_o` rises right after the clock edge that brings the (N·DIV)-th `xtal_en_i` pulse counted while waiting. DIV defaults to 32. A cycle counts as waiting when `bus_req_i`=1 and `bus_gnt_i`=0, except the first cycle of the request.
- R4: With limit 0, `merr_o` is never set, however long the wait lasts.
- R5: While `bus_gnt_i` is 1, no time accumulates. If the grant drops while the request stays high, counting resumes from the held value.
- R6: A rising edge of `bus_req_i` clears the accumulated wait and the prescaler. That cycle is not counted.
- R7: `merr_o` stays set until a cycle with `err_w1c_i`=1. If a timeout and a clear fall in the same cycle, the timeout wins.
- R8: `irq_o` is 1 exactly when `merr_o`=1, `err_mask_i`=0 and `int_en_i`=1.
- R9: `reg_wr_i` changes the limit only while `stop_i`=1. While `stop_i`=0, `reg_rdata_o` reads 0. Entering the stopped state leaves the limit unchanged.
- R10: Only cycles with `xtal_en_i`=1 advance time. A sparser enable stretches the timeout in proportion.
- R11: A request times out at most once. After a clear during the same request, `merr_o` stays 0 until a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| xtal_en_i | input | 1 | One pulse per crystal clock period |
| bus_req_i | input | 1 | Master requests the bus |
| bus_gnt_i | input | 1 | Bus granted to the master |
| stop_i | input | 1 | Controller is in the stopped state |
| reg_wr_i | input | 1 | Write strobe for the limit register |
| reg_wdata_i | input | 16 | Limit write data |
| reg_rdata_o | output | 16 | Limit readback (0 when not stopped) |
| err_w1c_i | input | 1 | Host writes one to clear the error flag |
| err_mask_i | input | 1 | Masks the error interrupt when 1 |
| int_en_i | input | 1 | Global interrupt enable |
| merr_o | output | 1 | Sticky memory-error (bus timeout) flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the exact cycle of the timeout. It does this with a small limit, with the default limit of 512 units, and with a gapped crystal enable. A prescaler that is off by one pulse, or that counts the request's first cycle, would move the flag by a cycle and fail the comparison. Grant windows and re-raised requests check that the wait is held and restarted. A monitor that ignored the grant or kept counting across requests would flag too early. The remaining cases are:
- a zero limit, which must never fire;
- writes made while running, which must not change the limit;
- a clear arriving together with a timeout, where a reversed priority would drop the error;
- a clear made during the same long wait, where a monitor that fires again would set the flag a second time.

// File: rtl/buswait_pkg.sv
package buswait_pkg;

    localparam int unsigned LIMIT_BITS  = 16;
    localparam int unsigned XTAL_DIV    = 32;
    localparam logic [15:0] LIMIT_RESET = 16'h0200;

    // per-cycle request qualifiers handed to the prescaler and counter
    typedef struct packed {
        logic restart;   // first cycle of a new request
        logic waiting;   // requesting, not granted, not first cycle
    } wait_ctl_t;

    // interrupt gate: error flag, mask (active high), global enable
    function automatic logic irq_gate(input logic flag, input logic mask, input logic enable);
        return flag & ~mask & enable;
    endfunction

endpackage

// File: rtl/buswait_prescale.sv
module buswait_prescale #(
    parameter int unsigned DIV = buswait_pkg::XTAL_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic restart,
    input  logic run,
    input  logic xtal_en,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;
    logic          at_last;

    assign at_last = (phase_q == LAST);
    assign tick    = run & xtal_en & at_last;

    always_ff @(posedge clk) begin
        if (rst || soft_rst || restart) begin
            phase_q <= '0;
        end else if (run && xtal_en) begin
            phase_q <= at_last ? '0 : phase_q + PW'(1);
        end
    end
endmodule

// File: rtl/buswait_limit.sv
module buswait_limit #(
    parameter int unsigned  LIM_W   = buswait_pkg::LIMIT_BITS,
    parameter logic [LIM_W-1:0] RST_VAL = LIM_W'(buswait_pkg::LIMIT_RESET)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             stop,
    input  logic             wr,
    input  logic [LIM_W-1:0] wdata,
    output logic [LIM_W-1:0] limit,
    output logic [LIM_W-1:0] rdata
);
    logic [LIM_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            value_q <= RST_VAL;
        end else if (stop && wr) begin
            value_q <= wdata;
        end
    end

    assign limit = value_q;
    assign rdata = stop ? value_q : '0;
endmodule

// File: rtl/buswait_counter.sv
module buswait_counter #(
    parameter int unsigned LIM_W = buswait_pkg::LIMIT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             hit
);
    logic [LIM_W-1:0] units_q;
    logic             fired_q;
    logic [LIM_W-1:0] units_next;

    assign units_next = units_q + LIM_W'(1);
    assign hit = tick & ~fired_q & (limit != '0) & (units_next == limit);

    always_ff @(posedge clk) begin
        if (rst || soft_rst || restart) begin
            units_q <= '0;
            fired_q <= 1'b0;
        end else if (tick) begin
            if (units_q != '1) begin
                units_q <= units_next;
            end
            if (hit) begin
                fired_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/buswait_mon.sv
module buswait_mon
    import buswait_pkg::*;
#(
    parameter int unsigned LIM_W = LIMIT_BITS,
    parameter int unsigned DIV   = XTAL_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst_i,
    input  logic             xtal_en_i,
    input  logic             bus_req_i,
    input  logic             bus_gnt_i,
    input  logic             stop_i,
    input  logic             reg_wr_i,
    input  logic [LIM_W-1:0] reg_wdata_i,
    output logic [LIM_W-1:0] reg_rdata_o,
    input  logic             err_w1c_i,
    input  logic             err_mask_i,
    input  logic             int_en_i,
    output logic             merr_o,
    output logic             irq_o
);
    logic             req_q;
    wait_ctl_t        ctl;
    logic             tick;
    logic             hit;
    logic             merr_q;
    logic [LIM_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            req_q <= 1'b0;
        end else begin
            req_q <= bus_req_i;
        end
    end

    always_comb begin
        ctl.restart = bus_req_i & ~req_q;
        ctl.waiting = bus_req_i & ~bus_gnt_i & ~ctl.restart;
    end

    buswait_prescale #(.DIV(DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst_i),
        .restart  (ctl.restart),
        .run      (ctl.waiting),
        .xtal_en  (xtal_en_i),
        .tick     (tick)
    );

    buswait_limit #(.LIM_W(LIM_W)) u_lim (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst_i),
        .stop     (stop_i),
        .wr       (reg_wr_i),
        .wdata    (reg_wdata_i),
        .limit    (limit_q),
        .rdata    (reg_rdata_o)
    );

    buswait_counter #(.LIM_W(LIM_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst_i),
        .restart  (ctl.restart),
        .tick     (tick),
        .limit    (limit_q),
        .hit      (hit)
    );

    // sticky error: a timeout takes priority over a host clear
    always_ff @(posedge clk) begin
        if (rst || soft_rst_i) begin
            merr_q <= 1'b0;
        end else if (hit) begin
            merr_q <= 1'b1;
        end else if (err_w1c_i) begin
            merr_q <= 1'b0;
        end
    end

    assign merr_o = merr_q;
    assign irq_o  = irq_gate(merr_q, err_mask_i, int_en_i);
endmodule

// File: rtl/buswait_mon_chk.sv
module buswait_mon_chk #(
    parameter int unsigned LIM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst_i,
    input logic             stop_i,
    input logic             bus_req_i,
    input logic             bus_gnt_i,
    input logic             err_w1c_i,
    input logic             int_en_i,
    input logic             merr_o,
    input logic             irq_o,
    input logic [LIM_W-1:0] reg_rdata_o,
    input logic [LIM_W-1:0] limit_q
);
    // R7: flag holds without a clear or soft reset
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (merr_o && !err_w1c_i && !soft_rst_i) |=> merr_o);

    // R4: zero limit never produces an error
    p_zero_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (limit_q == '0 && !merr_o) |=> !merr_o);

    // R3: an error only rises after a cycle of genuine waiting
    p_rise_waiting_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(merr_o) |-> $past(bus_req_i && !bus_gnt_i));

    // R9: limit frozen while running
    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (!stop_i && !soft_rst_i) |=> $stable(limit_q));

    // R9: readback hidden while running
    p_hidden_r9: assert property (@(posedge clk) disable iff (rst)
        !stop_i |-> (reg_rdata_o == '0));

    // R8: no interrupt without an error and the enable
    p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (merr_o && int_en_i));
endmodule

bind buswait_mon buswait_mon_chk #(.LIM_W(LIM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .soft_rst_i  (soft_rst_i),
    .stop_i      (stop_i),
    .bus_req_i   (bus_req_i),
    .bus_gnt_i   (bus_gnt_i),
    .err_w1c_i   (err_w1c_i),
    .int_en_i    (int_en_i),
    .merr_o      (merr_o),
    .irq_o       (irq_o),
    .reg_rdata_o (reg_rdata_o),
    .limit_q     (limit_q)
);

// File: tb/buswait_mon_test.sv
`timescale 1ns/1ps
module buswait_mon_test;
    localparam int DIV = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst_i = 1'b0;
    logic        xtal_en_i = 1'b1;
    logic        bus_req_i = 1'b0;
    logic        bus_gnt_i = 1'b0;
    logic        stop_i = 1'b1;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        err_w1c_i = 1'b0;
    logic        err_mask_i = 1'b0;
    logic        int_en_i = 1'b1;
    logic        merr_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit live  = 0;

    always #2.5 clk = ~clk;

    buswait_mon uut (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .xtal_en_i(xtal_en_i),
        .bus_req_i(bus_req_i), .bus_gnt_i(bus_gnt_i), .stop_i(stop_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .err_w1c_i(err_w1c_i), .err_mask_i(err_mask_i), .int_en_i(int_en_i),
        .merr_o(merr_o), .irq_o(irq_o)
    );

    // reference model: counts raw crystal pulses spent waiting
    int m_lim = 512;
    int m_pulses = 0;
    bit m_fired = 0;
    bit m_merr = 0;
    bit m_req_prev = 0;

    always @(posedge clk) begin
        bit fire;
        fire = 0;
        if (rst || soft_rst_i) begin
            m_lim = 512; m_pulses = 0; m_fired = 0; m_merr = 0; m_req_prev = 0;
        end else begin
            if (bus_req_i && !m_req_prev) begin
                m_pulses = 0; m_fired = 0;
            end else if (bus_req_i && !bus_gnt_i && xtal_en_i) begin
                m_pulses++;
                if (!m_fired && m_lim != 0 && m_pulses == m_lim * DIV) begin
                    m_fired = 1; fire = 1;
                end
            end
            if (fire) m_merr = 1;
            else if (err_w1c_i) m_merr = 0;
            if (stop_i && reg_wr_i) m_lim = int'(reg_wdata_i);
            m_req_prev = bus_req_i;
        end
        #1;
        if (live) begin
            tests += 3;
            if (merr_o !== m_merr) begin
                fails++;
                $display("FAIL R3 cycle model merr: got %0b exp %0b", merr_o, m_merr);
            end
            if (irq_o !== (m_merr && !err_mask_i && int_en_i)) begin
                fails++;
                $display("FAIL R8 cycle model irq: got %0b exp %0b", irq_o,
                         (m_merr && !err_mask_i && int_en_i));
            end
            if (reg_rdata_o !== (stop_i ? 16'(m_lim) : 16'h0)) begin
                fails++;
                $display("FAIL R9 cycle model rdata: got %h exp %h", reg_rdata_o,
                         (stop_i ? 16'(m_lim) : 16'h0));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic write_lim(input logic [15:0] v);
        reg_wdata_i = v; reg_wr_i = 1'b1;
        step(1);
        reg_wr_i = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5 * 100000);
        fails++;
        $display("FAIL watchdog: got hung exp finished");
        summary();
    end

    initial begin
        step(3);
        rst = 1'b0;
        live = 1;
        step(1);
        // R1 reset state
        check("R1 merr after reset", merr_o, 0);
        check("R1 irq after reset", irq_o, 0);
        check("R1 limit after reset", reg_rdata_o, 16'h0200);

        // R9 stopped write, running write ignored, readback hidden
        write_lim(16'd3);
        check("R9 stopped write", reg_rdata_o, 3);
        stop_i = 1'b0;
        write_lim(16'd7);
        check("R9 readback hidden", reg_rdata_o, 0);
        stop_i = 1'b1;
        step(1);
        check("R9 running write ignored", reg_rdata_o, 3);

        // R3 exact timing, limit 3 -> 96 pulses after first cycle
        bus_req_i = 1'b1;
        step(96);
        check("R3 no error one cycle early", merr_o, 0);
        step(1);
        check("R3 error on time", merr_o, 1);
        check("R8 irq enabled", irq_o, 1);
        err_mask_i = 1'b1; step(1);
        check("R8 irq masked", irq_o, 0);
        err_mask_i = 1'b0; int_en_i = 1'b0; step(1);
        check("R8 irq disabled", irq_o, 0);
        int_en_i = 1'b1;

        // R7 clear, R11 no re-fire within same request
        err_w1c_i = 1'b1; step(1); err_w1c_i = 1'b0;
        check("R7 clear", merr_o, 0);
        step(300);
        check("R11 single fire per request", merr_o, 0);

        // R6 restart on new request
        bus_req_i = 1'b0; step(1);
        bus_req_i = 1'b1; step(50);
        bus_req_i = 1'b0; step(1);
        bus_req_i = 1'b1; step(96);
        check("R6 restart no early error", merr_o, 0);
        step(1);
        check("R6 error after restart", merr_o, 1);
        bus_req_i = 1'b0; err_w1c_i = 1'b1; step(1); err_w1c_i = 1'b0;

        // R5 grant pauses counting
        bus_req_i = 1'b1; step(41);
        bus_gnt_i = 1'b1; step(200);
        check("R5 no count during grant", merr_o, 0);
        bus_gnt_i = 1'b0; step(55);
        check("R5 held count not yet expired", merr_o, 0);
        step(1);
        check("R5 resumed count expires", merr_o, 1);
        bus_req_i = 1'b0; err_w1c_i = 1'b1; step(1); err_w1c_i = 1'b0;

        // R10 gapped crystal enable doubles time
        bus_req_i = 1'b1;
        for (int i = 0; i < 150; i++) begin
            xtal_en_i = (i % 2 == 1);
            step(1);
        end
        check("R10 gapped enable slower", merr_o, 0);
        for (int i = 0; i < 60; i++) begin
            xtal_en_i = (i % 2 == 1);
            step(1);
        end
        check("R10 gapped enable expires", merr_o, 1);
        xtal_en_i = 1'b1;
        bus_req_i = 1'b0; err_w1c_i = 1'b1; step(1); err_w1c_i = 1'b0;

        // R7 timeout wins over simultaneous clear, limit 1 -> 32 pulses
        write_lim(16'd1);
        err_w1c_i = 1'b1;
        bus_req_i = 1'b1; step(33);
        check("R7 set beats clear", merr_o, 1);
        step(1);
        check("R7 clear next cycle", merr_o, 0);
        err_w1c_i = 1'b0;
        bus_req_i = 1'b0; step(1);

        // R4 zero limit never fires
        write_lim(16'd0);
        bus_req_i = 1'b1; step(5000);
        check("R4 zero limit quiet", merr_o, 0);
        bus_req_i = 1'b0; step(1);

        // R2 soft reset reloads default and clears flag
        write_lim(16'd5);
        soft_rst_i = 1'b1; step(1); soft_rst_i = 1'b0;
        check("R2 soft reset limit", reg_rdata_o, 16'h0200);
        check("R2 soft reset flag", merr_o, 0);

        // R1 default limit 512 -> 16384 pulses; stop entry keeps value (R9)
        stop_i = 1'b0; step(2); stop_i = 1'b1; step(1);
        check("R9 stop entry keeps limit", reg_rdata_o, 16'h0200);
        bus_req_i = 1'b1; step(16384);
        check("R1 default limit not early", merr_o, 0);
        step(1);
        check("R1 default limit 51.2us", merr_o, 1);
        bus_req_i = 1'b0;
        step(2);
        summary();
    end
endmodule